// File: doc/BRIEF.md
# Asynchronous Static RAM Byte-Lane Controller

This block sits between a clocked host and an external asynchronous static RAM of 256K sixteen-bit words. The host presents one request at a time: a read or write flag, an 18-bit word address, sixteen bits of write data and a two-bit lane mask. It holds these steady until the controller answers with a one-cycle done pulse. The controller then runs one memory cycle on the active-low chip-enable, write-enable and output-enable pins and the two active-low byte strobes. Each byte strobe gates one eight-bit half of the shared tri-state data bus.

Every phase of a memory cycle lasts a whole number of clocks. Each count is the relevant timing limit for the chosen speed grade divided by the clock period and rounded up, with at least one cycle per phase. Two phases exist only for safety. A wait on an idle bus separates a read from a following write, so the memory's outputs are off before the controller drives. A recovery wait follows the end of low-voltage data retention before any access may start. Between requests the device is deselected.

Top module: `asram_lane_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, chip enable, write enable, output enable and both byte strobes are high and done is low.
- R2: Lane mask bit 0 selects data bits 7..0 through byte strobe bit 0, and mask bit 1 selects bits 15..8 through byte strobe bit 1. A write changes only the selected lanes in memory.
- R3: A write holds chip enable, write enable and the selected strobes low together for exactly WR = ceil(max(tWP, tCW, tAW, tDW) / Tclk) cycles (13 at the fastest grade with a 4 ns clock), and output enable stays high throughout.
- R4: The memory address is held stable while chip enable is low. A write that does not follow a read signals done 1 + WR + TAIL clock edges after the request is taken, where TAIL = max(1, ceil(tWC / Tclk) - WR).
- R5: A read drives output enable low and write enable high with the selected strobes for RD = ceil(max(tRC, tAA, tOE) / Tclk) cycles and captures the bus on the last of them. Done follows 1 + RD edges after the request. Unselected lanes of the read result are zero.
- R6: A write that follows a read first waits TURN = ceil(tHZ / Tclk) cycles with every control pin high, so its done comes 1 + TURN + WR + TAIL edges after the request. A write that follows a write does not wait.
- R7: A request with lane mask 00 is answered by done one edge after it is taken, and chip enable does not go low.
- R8: While the supply-low input is high the device stays deselected and requests wait. After the input falls, no access starts until ceil(tRC / Tclk) cycles have passed.
- R9: Done is high for exactly one cycle per request, and the controller returns to the deselected state after every access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| supplyLow | input | 1 | High while the memory supply is at retention level |
| hostReq | input | 1 | Request, held with its fields until done |
| hostWrite | input | 1 | 1 for a write, 0 for a read |
| hostAddr | input | 18 | Word address |
| hostWdata | input | 16 | Write data |
| hostMask | input | 2 | Lane select, bit 0 low byte, bit 1 high byte |
| hostRdata | output | 16 | Captured read data, unselected lanes zero |
| hostDone | output | 1 | One-cycle completion pulse |
| memAddr | output | 18 | Memory address |
| memData | inout | 16 | Shared data bus |
| memCeN | output | 1 | Chip enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memOeN | output | 1 | Output enable, active low |
| memByteN | output | 2 | Byte strobes, bit 0 low byte, bit 1 high byte, active low |

## Verification
Suppose the phase counter or the state register goes wrong. Done then arrives on the wrong edge, and the latency checks catch this at the end of the same request. A strobe pulse that is too short shows at the memory pins the moment write enable rises, because the model times every write. A missing turnaround shows when the next write's strobes fall, which is too soon after the read driver is released. A wrong lane decode or an early capture stays hidden until a later read returns the stored word, which is why each write is followed by a full-width read.

// File: rtl/asram_pkg.sv
package asram_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // latch host fields
    logic sel;      // chip selected
    logic wr;       // write phase: drive bus, write enable low
    logic rd;       // read phase: output enable low
    logic capture;  // sample bus into read register
  } ctrl_t;

  typedef struct packed {
    int unsigned wcPs;
    int unsigned wpPs;
    int unsigned cwPs;
    int unsigned awPs;
    int unsigned dwPs;
    int unsigned rcPs;
    int unsigned aaPs;
    int unsigned oePs;
    int unsigned hzPs;
  } limits_t;

  function automatic limits_t gradeLimits(input int unsigned grade);
    limits_t l;
    case (grade)
      1:       l = '{70000, 50000, 60000, 60000, 30000, 70000, 70000, 35000, 25000};
      2:       l = '{100000, 70000, 80000, 80000, 40000, 100000, 100000, 50000, 30000};
      default: l = '{55000, 45000, 50000, 50000, 25000, 55000, 55000, 30000, 20000};
    endcase
    return l;
  endfunction

  function automatic int unsigned maxOf(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned ceilCycles(input int unsigned ps, input int unsigned clkPs);
    int unsigned c;
    c = (ps + clkPs - 1) / clkPs;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned writeCycles(input int unsigned grade, input int unsigned clkPs);
    limits_t l;
    l = gradeLimits(grade);
    return ceilCycles(maxOf(maxOf(l.wpPs, l.cwPs), maxOf(l.awPs, l.dwPs)), clkPs);
  endfunction

  function automatic int unsigned tailCycles(input int unsigned grade, input int unsigned clkPs);
    int unsigned wc;
    int unsigned w;
    wc = ceilCycles(gradeLimits(grade).wcPs, clkPs);
    w  = writeCycles(grade, clkPs);
    return (wc > w) ? (wc - w) : 1;
  endfunction

  function automatic int unsigned readCycles(input int unsigned grade, input int unsigned clkPs);
    limits_t l;
    l = gradeLimits(grade);
    return ceilCycles(maxOf(maxOf(l.rcPs, l.aaPs), l.oePs), clkPs);
  endfunction

  function automatic int unsigned turnCycles(input int unsigned grade, input int unsigned clkPs);
    return ceilCycles(gradeLimits(grade).hzPs, clkPs);
  endfunction

  function automatic int unsigned recoverCycles(input int unsigned grade, input int unsigned clkPs);
    return ceilCycles(gradeLimits(grade).rcPs, clkPs);
  endfunction

endpackage

// File: rtl/asram_ctrl_fsm.sv
module asram_ctrl_fsm
  import asram_pkg::*;
#(
  parameter int unsigned WR_CYC   = 13,
  parameter int unsigned TAIL_CYC = 1,
  parameter int unsigned RD_CYC   = 14,
  parameter int unsigned TURN_CYC = 5,
  parameter int unsigned REC_CYC  = 14,
  parameter int unsigned CNT_W    = 4,
  parameter int unsigned LANES    = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             supplyLow,
  input  logic             hostReq,
  input  logic             hostWrite,
  input  logic [LANES-1:0] hostMask,
  output ctrl_t            ctrl,
  output logic             hostDone
);

  typedef enum logic [2:0] {
    S_IDLE, S_TURN, S_WRITE, S_WTAIL, S_READ, S_RETAIN, S_RECOV
  } state_e;

  localparam logic [CNT_W-1:0] WR_LD   = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] TAIL_LD = CNT_W'(TAIL_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LD = CNT_W'(TURN_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LD  = CNT_W'(REC_CYC - 1);

  state_e           stateQ, stateD;
  logic [CNT_W-1:0] cntQ, cntD;
  logic             doneQ, doneD;
  logic             lastRdQ, lastRdD;
  logic             cntZero;

  assign cntZero  = (cntQ == '0);
  assign hostDone = doneQ;

  always_comb begin
    stateD  = stateQ;
    cntD    = cntZero ? cntQ : cntQ - 1'b1;
    doneD   = 1'b0;
    lastRdD = lastRdQ;
    ctrl    = '0;
    unique case (stateQ)
      S_IDLE: begin
        if (supplyLow) begin
          stateD = S_RETAIN;
        end else if (hostReq && !doneQ) begin
          if (hostMask == '0) begin
            doneD = 1'b1;
          end else begin
            ctrl.load = 1'b1;
            if (!hostWrite) begin
              stateD = S_READ;
              cntD   = RD_LD;
            end else if (lastRdQ) begin
              stateD = S_TURN;
              cntD   = TURN_LD;
            end else begin
              stateD = S_WRITE;
              cntD   = WR_LD;
            end
          end
        end
      end
      S_TURN: begin
        if (cntZero) begin
          stateD = S_WRITE;
          cntD   = WR_LD;
        end
      end
      S_WRITE: begin
        ctrl.sel = 1'b1;
        ctrl.wr  = 1'b1;
        if (cntZero) begin
          stateD  = S_WTAIL;
          cntD    = TAIL_LD;
          lastRdD = 1'b0;
        end
      end
      S_WTAIL: begin
        if (cntZero) begin
          stateD = S_IDLE;
          doneD  = 1'b1;
        end
      end
      S_READ: begin
        ctrl.sel = 1'b1;
        ctrl.rd  = 1'b1;
        if (cntZero) begin
          ctrl.capture = 1'b1;
          stateD       = S_IDLE;
          doneD        = 1'b1;
          lastRdD      = 1'b1;
        end
      end
      S_RETAIN: begin
        if (!supplyLow) begin
          stateD = S_RECOV;
          cntD   = REC_LD;
        end
      end
      S_RECOV: begin
        if (supplyLow)    stateD = S_RETAIN;
        else if (cntZero) stateD = S_IDLE;
      end
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= S_IDLE;
      cntQ    <= '0;
      doneQ   <= 1'b0;
      lastRdQ <= 1'b0;
    end else begin
      stateQ  <= stateD;
      cntQ    <= cntD;
      doneQ   <= doneD;
      lastRdQ <= lastRdD;
    end
  end

endmodule

// File: rtl/asram_datapath.sv
module asram_datapath
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 2,
  localparam int unsigned DATA_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [LANES-1:0]  hostMask,
  output logic [DATA_W-1:0] hostRdata,
  output logic [ADDR_W-1:0] memAddr,
  inout  wire  [DATA_W-1:0] memData,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [LANES-1:0]  memByteN
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [LANES-1:0]  maskQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
      maskQ <= '0;
    end else if (ctrl.load) begin
      addrQ <= hostAddr;
      dataQ <= hostWdata;
      maskQ <= hostMask;
    end
  end

  assign memAddr = addrQ;
  assign memCeN  = ~ctrl.sel;
  assign memWeN  = ~ctrl.wr;
  assign memOeN  = ~ctrl.rd;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] rdLaneQ;

    assign memByteN[g] = ~(ctrl.sel & maskQ[g]);
    assign memData[g*LANE_W +: LANE_W] = ctrl.wr ? dataQ[g*LANE_W +: LANE_W] : {LANE_W{1'bz}};

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             rdLaneQ <= '0;
      else if (ctrl.capture) rdLaneQ <= maskQ[g] ? memData[g*LANE_W +: LANE_W] : '0;
    end

    assign hostRdata[g*LANE_W +: LANE_W] = rdLaneQ;
  end

endmodule

// File: rtl/asram_lane_ctrl.sv
module asram_lane_ctrl
  import asram_pkg::*;
#(
  parameter int unsigned SPEED_GRADE   = 0,
  parameter int unsigned CLK_PERIOD_PS = 4000,
  parameter int unsigned ADDR_W        = 18,
  parameter int unsigned DATA_W        = 16,
  parameter int unsigned LANE_W        = 8,
  localparam int unsigned LANES        = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              supplyLow,
  input  logic              hostReq,
  input  logic              hostWrite,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [LANES-1:0]  hostMask,
  output logic [DATA_W-1:0] hostRdata,
  output logic              hostDone,
  output logic [ADDR_W-1:0] memAddr,
  inout  wire  [DATA_W-1:0] memData,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [LANES-1:0]  memByteN
);

  localparam int unsigned WR_CYC   = writeCycles(SPEED_GRADE, CLK_PERIOD_PS);
  localparam int unsigned TAIL_CYC = tailCycles(SPEED_GRADE, CLK_PERIOD_PS);
  localparam int unsigned RD_CYC   = readCycles(SPEED_GRADE, CLK_PERIOD_PS);
  localparam int unsigned TURN_CYC = turnCycles(SPEED_GRADE, CLK_PERIOD_PS);
  localparam int unsigned REC_CYC  = recoverCycles(SPEED_GRADE, CLK_PERIOD_PS);
  localparam int unsigned MAX_CYC  = maxOf(maxOf(maxOf(WR_CYC, TAIL_CYC), maxOf(RD_CYC, TURN_CYC)), REC_CYC);
  localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

  ctrl_t ctrlS;

  asram_ctrl_fsm #(
    .WR_CYC  (WR_CYC),
    .TAIL_CYC(TAIL_CYC),
    .RD_CYC  (RD_CYC),
    .TURN_CYC(TURN_CYC),
    .REC_CYC (REC_CYC),
    .CNT_W   (CNT_W),
    .LANES   (LANES)
  ) u_fsm (
    .clk      (clk),
    .rstN     (rstN),
    .supplyLow(supplyLow),
    .hostReq  (hostReq),
    .hostWrite(hostWrite),
    .hostMask (hostMask),
    .ctrl     (ctrlS),
    .hostDone (hostDone)
  );

  asram_datapath #(
    .ADDR_W(ADDR_W),
    .LANE_W(LANE_W),
    .LANES (LANES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrlS),
    .hostAddr (hostAddr),
    .hostWdata(hostWdata),
    .hostMask (hostMask),
    .hostRdata(hostRdata),
    .memAddr  (memAddr),
    .memData  (memData),
    .memCeN   (memCeN),
    .memWeN   (memWeN),
    .memOeN   (memOeN),
    .memByteN (memByteN)
  );

endmodule

// File: rtl/asram_lane_ctrl_chk.sv
module asram_lane_ctrl_chk
  import asram_pkg::*;
#(
  parameter int unsigned SPEED_GRADE   = 0,
  parameter int unsigned CLK_PERIOD_PS = 4000,
  parameter int unsigned ADDR_W        = 18,
  parameter int unsigned LANES         = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              supplyLow,
  input logic              hostDone,
  input logic              memCeN,
  input logic              memWeN,
  input logic              memOeN,
  input logic [LANES-1:0]  memByteN,
  input logic [ADDR_W-1:0] memAddr
);

  localparam int unsigned WR_CYC  = writeCycles(SPEED_GRADE, CLK_PERIOD_PS);
  localparam int unsigned REC_CYC = recoverCycles(SPEED_GRADE, CLK_PERIOD_PS);

  int unsigned wrRun;
  int unsigned sinceUp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrRun   <= 0;
      sinceUp <= REC_CYC;
    end else begin
      wrRun   <= memWeN ? 0 : wrRun + 1;
      sinceUp <= supplyLow ? 0 : ((sinceUp >= REC_CYC) ? REC_CYC : sinceUp + 1);
    end
  end

  a_r3_oe_high_in_write: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (memOeN && !memCeN));

  a_r3_write_pulse_len: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (wrRun == WR_CYC));

  a_r2_lane_on_access: assert property (@(posedge clk) disable iff (!rstN)
    !memCeN |-> (memByteN != '1));

  a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && $past(!memCeN)) |-> $stable(memAddr));

  a_r5_read_we_high: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> memWeN);

  a_r8_recovery: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memCeN) |-> (sinceUp >= REC_CYC));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    hostDone |=> !hostDone);

endmodule

bind asram_lane_ctrl asram_lane_ctrl_chk #(
  .SPEED_GRADE  (SPEED_GRADE),
  .CLK_PERIOD_PS(CLK_PERIOD_PS),
  .ADDR_W       (ADDR_W),
  .LANES        (LANES)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .supplyLow(supplyLow),
  .hostDone (hostDone),
  .memCeN   (memCeN),
  .memWeN   (memWeN),
  .memOeN   (memOeN),
  .memByteN (memByteN),
  .memAddr  (memAddr)
);

// File: tb/asram_lane_ctrl_bench.sv
module asram_lane_ctrl_bench;
  timeunit 1ns;
  timeprecision 1ps;

  // limits in ns for the fastest grade, clock 4 ns
  localparam int TCLK = 4;
  function automatic int cdiv(input int ns);
    return (ns + TCLK - 1) / TCLK;
  endfunction
  localparam int WR   = cdiv(50);
  localparam int TAIL = (cdiv(55) > WR) ? cdiv(55) - WR : 1;
  localparam int RD   = cdiv(55);
  localparam int TURN = cdiv(20);
  localparam int REC  = cdiv(55);
  localparam int LAT_W  = 1 + WR + TAIL;
  localparam int LAT_WR = 1 + TURN + WR + TAIL;
  localparam int LAT_R  = 1 + RD;

  logic        clk, rstN, supplyLow, hostReq, hostWrite;
  logic [17:0] hostAddr;
  logic [15:0] hostWdata;
  logic [1:0]  hostMask;
  logic [15:0] hostRdata;
  logic        hostDone;
  logic [17:0] memAddr;
  wire  [15:0] memData;
  logic        memCeN, memWeN, memOeN;
  logic [1:0]  memByteN;

  int testsRun = 0;
  int failsN   = 0;

  asram_lane_ctrl u_asram_lane_ctrl (
    .clk(clk), .rstN(rstN), .supplyLow(supplyLow), .hostReq(hostReq),
    .hostWrite(hostWrite), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostMask(hostMask), .hostRdata(hostRdata), .hostDone(hostDone),
    .memAddr(memAddr), .memData(memData), .memCeN(memCeN), .memWeN(memWeN),
    .memOeN(memOeN), .memByteN(memByteN)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    testsRun++;
    if (act != exp) begin
      failsN++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chkMin(input string req, input string what, input real act, input real lim);
    testsRun++;
    if (act < lim) begin
      failsN++;
      $display("FAIL %s %s: actual %0.1f expected at least %0.1f", req, what, act, lim);
    end
  endtask

  // ---------------- behavioural memory with timing checks ----------------
  logic [15:0] mdl [256];
  logic        rdReady = 1'b0;
  logic        anyRead = 1'b0;
  logic        pwrSeen = 1'b0;
  realtime     tRdStart = 0, tRdEnd = 0, tWrStart = 0, tPwrUp = 0;
  logic [15:0] wrData = '0;
  logic [1:0]  wrLanes = '0;
  logic [17:0] wrAddr = '0;
  int          ceFalls = 0;

  wire rdCond = !memCeN && memWeN && !memOeN && (memByteN != 2'b11);
  wire wrCond = !memCeN && !memWeN && (memByteN != 2'b11);

  assign memData[7:0]  = (rdCond && !memByteN[0]) ? (rdReady ? mdl[memAddr[7:0]][7:0]  : 8'hxx) : 8'hzz;
  assign memData[15:8] = (rdCond && !memByteN[1]) ? (rdReady ? mdl[memAddr[7:0]][15:8] : 8'hxx) : 8'hzz;

  initial for (int i = 0; i < 256; i++) mdl[i] = 16'h0000;

  always @(posedge rdCond) begin
    tRdStart = $realtime;
    rdReady  = 1'b0;
  end
  always @(negedge rdCond) begin
    tRdEnd  = $realtime;
    anyRead = 1'b1;
  end

  initial forever begin
    #1;
    rdReady = rdCond && (($realtime - tRdStart) >= 55.0);
    if (wrCond) wrData = memData;
  end

  always @(posedge wrCond) begin
    tWrStart = $realtime;
    wrLanes  = ~memByteN;
    wrAddr   = memAddr;
    if (anyRead) chkMin("R6", "ns from read release to write start", $realtime - tRdEnd, 20.0);
  end
  always @(negedge wrCond) begin
    chkMin("R3", "write pulse ns", $realtime - tWrStart, 50.0);
    chk("R4", "address stable in write", memAddr, wrAddr);
    if (wrLanes[0]) mdl[wrAddr[7:0]][7:0]  = wrData[7:0];
    if (wrLanes[1]) mdl[wrAddr[7:0]][15:8] = wrData[15:8];
  end

  always @(negedge memCeN) begin
    ceFalls++;
    if (pwrSeen) chkMin("R8", "ns from supply up to access", $realtime - tPwrUp, 55.0);
  end
  always @(negedge supplyLow) begin
    tPwrUp  = $realtime;
    pwrSeen = 1'b1;
  end

  // ---------------- host request task ----------------
  task automatic doOp(input logic wr, input logic [17:0] a, input logic [15:0] d,
                      input logic [1:0] m, output int lat, output logic [15:0] rd);
    @(negedge clk);
    hostReq = 1'b1; hostWrite = wr; hostAddr = a; hostWdata = d; hostMask = m;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!hostDone && lat < 1000);
    rd = hostRdata;
    hostReq = 1'b0;
  endtask

  typedef struct packed {
    logic        wr;
    logic [17:0] addr;
    logic [15:0] data;
    logic [1:0]  mask;
    logic [15:0] expRd;
    logic [7:0]  expLat;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{1'b1, 18'h00012, 16'hA5C3, 2'b11, 16'h0000, 8'(LAT_W)},   // R4 full write
    '{1'b0, 18'h00012, 16'h0000, 2'b11, 16'hA5C3, 8'(LAT_R)},   // R5 full read
    '{1'b1, 18'h00012, 16'h1234, 2'b01, 16'h0000, 8'(LAT_WR)},  // R2 R6 low lane write after read
    '{1'b0, 18'h00012, 16'h0000, 2'b11, 16'hA534, 8'(LAT_R)},   // R2 high lane kept
    '{1'b1, 18'h3FFFF, 16'hBEEF, 2'b10, 16'h0000, 8'(LAT_WR)},  // R2 high lane write
    '{1'b0, 18'h3FFFF, 16'h0000, 2'b11, 16'hBE00, 8'(LAT_R)},   // R2 low lane kept
    '{1'b0, 18'h00012, 16'h0000, 2'b01, 16'h0034, 8'(LAT_R)},   // R5 high lane zero
    '{1'b0, 18'h00012, 16'h0000, 2'b10, 16'hA500, 8'(LAT_R)},   // R5 low lane zero
    '{1'b1, 18'h00012, 16'hFFFF, 2'b00, 16'h0000, 8'd1},        // R7 empty mask
    '{1'b0, 18'h00012, 16'h0000, 2'b11, 16'hA534, 8'(LAT_R)}    // R7 nothing written
  };

  initial begin
    #400000;
    failsN++;
    testsRun++;
    $display("FAIL R9 watchdog: actual no finish expected finish");
    $display("[TB] %0d tests run, %0d failed", testsRun, failsN);
    $finish;
  end

  initial begin
    int lat;
    logic [15:0] rd;
    int ceBefore;
    logic bad;

    rstN = 1'b0; supplyLow = 1'b0; hostReq = 1'b0; hostWrite = 1'b0;
    hostAddr = '0; hostWdata = '0; hostMask = '0;
    repeat (3) @(negedge clk);
    chk("R1", "pins during reset", {memCeN, memWeN, memOeN, memByteN, hostDone}, 6'b111110);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "pins after reset", {memCeN, memWeN, memOeN, memByteN, hostDone}, 6'b111110);

    // vector table
    for (int i = 0; i < 10; i++) begin
      ceBefore = ceFalls;
      doOp(VECS[i].wr, VECS[i].addr, VECS[i].data, VECS[i].mask, lat, rd);
      chk(VECS[i].wr ? "R4/R6" : "R5", $sformatf("vector %0d latency", i), lat, VECS[i].expLat);
      if (!VECS[i].wr) chk("R2/R5", $sformatf("vector %0d read data", i), rd, VECS[i].expRd);
      if (VECS[i].mask == 2'b00) chk("R7", "no chip enable for empty mask", ceFalls, ceBefore);
    end

    // R9: done lasts one cycle and device returns to deselect
    @(negedge clk);
    chk("R9", "done after one cycle", hostDone, 0);
    chk("R9", "deselected between requests", memCeN, 1);

    // R6: write after read waits, write after write does not
    doOp(1'b1, 18'h00040, 16'h5A5A, 2'b11, lat, rd);
    chk("R6", "write after read latency", lat, LAT_WR);
    doOp(1'b1, 18'h00041, 16'h0F0F, 2'b11, lat, rd);
    chk("R6", "write after write latency", lat, LAT_W);
    doOp(1'b0, 18'h00040, 16'h0000, 2'b11, lat, rd);
    chk("R3", "readback after write", rd, 16'h5A5A);
    doOp(1'b0, 18'h00041, 16'h0000, 2'b11, lat, rd);
    chk("R3", "readback second write", rd, 16'h0F0F);

    // R8: retention standby and recovery
    @(negedge clk);
    supplyLow = 1'b1;
    @(negedge clk);
    hostReq = 1'b1; hostWrite = 1'b0; hostAddr = 18'h00012; hostMask = 2'b11;
    bad = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (!memCeN || hostDone) bad = 1'b1;
    end
    chk("R8", "held deselected in retention", bad, 0);
    supplyLow = 1'b0;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!hostDone && lat < 1000);
    rd = hostRdata;
    hostReq = 1'b0;
    chk("R8", "latency from supply up", lat, 1 + REC + 1 + RD);
    chk("R8", "read after recovery", rd, 16'hA534);

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", testsRun, failsN);
    $finish;
  end

endmodule